// File: doc/BRIEF.md
# Complementary PWM Dead-Band Generator with Interrupt Qualifier

This block sits behind a PWM timer. It takes one raw PWM level and drives a true output, which is active while the raw level is high, and a complementary output, which is active while the raw level is low. When either output is about to turn on, a programmable dead band first waits a number of system clocks. The number is a power of two, selected by a 3-bit code. The output that is turning off drops at once, so the two outputs are never active together.

The block also receives the timer's raw event strobes: reload, compare and input capture. It forwards as a single-cycle interrupt only the event classes that a 2-bit mode field enables. A status flag records whether the most recent forwarded interrupt came from an input capture. Both fields are loaded through a one-word configuration write port, and both reset to zero.

Top module: `pwm_deadband_irq`

## Requirements
- R1: `out_o` and `out_n_o` are never high in the same cycle.
- R2: With delay code 0, the output that becomes due goes high after the first clock edge that samples the new `pwm_i` level. That is the same edge on which the other output goes low.
- R3: With delay code n in 1..7, an output goes high 2^n cycles later than it would with code 0. Codes 6 and 7 give 64 and 128 cycles.
- R4: The output that is leaving its active state is low after the first edge that samples the opposite `pwm_i` level.
- R5: If `pwm_i` returns to its previous level before the delay has run out, the pending activation is dropped. The count restarts from zero for the output that has become due.
- R6: With interrupt mode 00 or 01, a reload, compare or capture strobe in a cycle gives `irq_o` high in the following cycle.
- R7: With interrupt mode 10, only a capture strobe raises `irq_o`.
- R8: With interrupt mode 11, only a reload or compare strobe raises `irq_o`.
- R9: `irq_o` is high only in the cycle after a cycle that held an enabled strobe.
- R10: Each time an interrupt is raised, `cap_src_o` is updated. It is set when an enabled capture strobe caused the interrupt, including when it arrived together with a reload or compare strobe. It is cleared otherwise, and it holds its value while no interrupt is raised.
- R11: After reset, both outputs, `irq_o` and `cap_src_o` are low, the delay code is 0 and the interrupt mode is 00.
- R12: A write with `cfg_we_i` high loads the delay code from `cfg_wdata_i[2:0]` and the interrupt mode from `cfg_wdata_i[4:3]`. The new values govern behaviour from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 5 | [2:0] delay code, [4:3] interrupt mode |
| pwm_i | input | 1 | Raw PWM level |
| evt_reload_i | input | 1 | Reload event strobe |
| evt_compare_i | input | 1 | Compare event strobe |
| evt_capture_i | input | 1 | Input capture event strobe |
| out_o | output | 1 | True PWM output, active high |
| out_n_o | output | 1 | Complementary PWM output, active high |
| irq_o | output | 1 | Qualified interrupt pulse |
| cap_src_o | output | 1 | Last interrupt came from a capture |

## Verification
The bench sweeps all eight delay codes with long runs at each level. A wrong shift, or an off-by-one in the count, would show as an output edge one or more cycles early or late. It toggles `pwm_i` faster than the delay, so a design that kept a stale count would raise an output early, and one that failed to cancel a pending activation would assert both outputs or raise the wrong one. It drives every combination of event strobes under each interrupt mode. This exposes a filter that passes a masked class, an interrupt that is held longer than one cycle, and a status flag that favours reload/compare on a tie or changes when no interrupt is raised. A delay code written in the middle of a run checks that the new value takes effect on the next edge.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  typedef enum logic [1:0] {
    IRQ_ANY_A = 2'b00,
    IRQ_ANY_B = 2'b01,
    IRQ_CAP   = 2'b10,
    IRQ_RC    = 2'b11
  } irq_mode_e;

  localparam int IRQ_MODE_W = 2;
endpackage

// File: rtl/pdb_cfg_regs.sv
module pdb_cfg_regs
  import pdb_pkg::*;
#(
  parameter int DLY_CODE_W = 3,
  localparam int CFG_W     = DLY_CODE_W + IRQ_MODE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CFG_W-1:0]      wdata_i,
  output logic [DLY_CODE_W-1:0] dly_code_o,
  output irq_mode_e             irq_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_code_o <= '0;
      irq_mode_o <= IRQ_ANY_A;
    end else if (we_i) begin
      dly_code_o <= wdata_i[DLY_CODE_W-1:0];
      irq_mode_o <= irq_mode_e'(wdata_i[CFG_W-1:DLY_CODE_W]);
    end
  end
endmodule

// File: rtl/pdb_deadband_ch.sv
module pdb_deadband_ch #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             due_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             act_o
);
  logic [CNT_W-1:0] cnt_q;

  // drop at once when not due; count up to the delay before turning on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      cnt_q <= '0;
    end else if (!due_i) begin
      act_o <= 1'b0;
      cnt_q <= '0;
    end else if (!act_o) begin
      if (cnt_q >= dly_i) act_o <= 1'b1;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pdb_irq_filter.sv
module pdb_irq_filter
  import pdb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  irq_mode_e mode_i,
  input  logic      evt_rc_i,
  input  logic      evt_cap_i,
  output logic      irq_o,
  output logic      cap_src_o
);
  logic cap_hit, rc_hit, any_hit;

  always_comb begin
    cap_hit = evt_cap_i && (mode_i != IRQ_RC);
    rc_hit  = evt_rc_i  && (mode_i != IRQ_CAP);
    any_hit = cap_hit || rc_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      cap_src_o <= 1'b0;
    end else begin
      irq_o <= any_hit;
      if (any_hit) cap_src_o <= cap_hit; // capture wins a tie
    end
  end
endmodule

// File: rtl/pwm_deadband_irq.sv
module pwm_deadband_irq
  import pdb_pkg::*;
#(
  parameter int  DLY_CODE_W = 3,
  localparam int CFG_W      = DLY_CODE_W + IRQ_MODE_W,
  localparam int MAX_DLY    = 1 << ((1 << DLY_CODE_W) - 1),
  localparam int CNT_W      = $clog2(MAX_DLY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             pwm_i,
  input  logic             evt_reload_i,
  input  logic             evt_compare_i,
  input  logic             evt_capture_i,
  output logic             out_o,
  output logic             out_n_o,
  output logic             irq_o,
  output logic             cap_src_o
);
  logic [DLY_CODE_W-1:0] dly_code;
  irq_mode_e             irq_mode;
  logic [CNT_W-1:0]      dly_val;
  logic [1:0]            due, act;

  pdb_cfg_regs #(.DLY_CODE_W(DLY_CODE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .dly_code_o (dly_code),
    .irq_mode_o (irq_mode)
  );

  always_comb begin
    if (dly_code == '0) dly_val = '0;
    else                dly_val = CNT_W'(1) << dly_code;
  end

  assign due = {~pwm_i, pwm_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_ch
    pdb_deadband_ch #(.CNT_W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .due_i  (due[gi]),
      .dly_i  (dly_val),
      .act_o  (act[gi])
    );
  end

  assign out_o   = act[0];
  assign out_n_o = act[1];

  pdb_irq_filter u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (irq_mode),
    .evt_rc_i  (evt_reload_i | evt_compare_i),
    .evt_cap_i (evt_capture_i),
    .irq_o     (irq_o),
    .cap_src_o (cap_src_o)
  );
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwm_i,
  input logic       evt_reload_i,
  input logic       evt_compare_i,
  input logic       evt_capture_i,
  input logic       out_o,
  input logic       out_n_o,
  input logic       irq_o,
  input logic       cap_src_o,
  input logic [2:0] dly_code,
  input logic [1:0] irq_mode
);
  logic evt_rc;
  assign evt_rc = evt_reload_i | evt_compare_i;

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_o && out_n_o)); // R1

  AST_ZERO_DLY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_code == 3'd0 && pwm_i) |=> out_o); // R2

  AST_TRUE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> !out_o); // R4

  AST_COMP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_i |=> !out_n_o); // R4

  AST_CAP_MODE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mode == 2'b10 && !evt_capture_i) |=> !irq_o); // R7

  AST_RC_MODE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mode == 2'b11 && !evt_rc) |=> !irq_o); // R8

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_rc || evt_capture_i) |=> !irq_o); // R9

  AST_CAP_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_capture_i && irq_mode != 2'b11) |=> (irq_o && cap_src_o)); // R10
endmodule

bind pwm_deadband_irq pdb_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwm_i         (pwm_i),
  .evt_reload_i  (evt_reload_i),
  .evt_compare_i (evt_compare_i),
  .evt_capture_i (evt_capture_i),
  .out_o         (out_o),
  .out_n_o       (out_n_o),
  .irq_o         (irq_o),
  .cap_src_o     (cap_src_o),
  .dly_code      (dly_code),
  .irq_mode      (irq_mode)
);

// File: tb/pwm_deadband_irq_test.sv
module pwm_deadband_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       pwm = 1'b0;
  logic       ev_rl = 1'b0, ev_cmp = 1'b0, ev_cap = 1'b0;
  logic       out, out_n, irq, cap_src;

  int checks = 0, failures = 0, cycles = 0;

  // reference model state
  int m_code = 0, m_mode = 0, run_lvl = -1, run_len = 0;
  bit e_out = 0, e_outn = 0, e_irq = 0, e_flag = 0;

  always #10 clk = ~clk;

  pwm_deadband_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .pwm_i(pwm), .evt_reload_i(ev_rl), .evt_compare_i(ev_cmp),
    .evt_capture_i(ev_cap), .out_o(out), .out_n_o(out_n),
    .irq_o(irq), .cap_src_o(cap_src)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_mode = 0; run_lvl = -1; run_len = 0;
      e_out = 0; e_outn = 0; e_irq = 0; e_flag = 0;
    end else begin
      int lvl, dly;
      bit cen, ren, hc, hr;
      cycles++;
      lvl = int'(pwm);
      if (lvl == run_lvl) run_len++;
      else begin run_lvl = lvl; run_len = 1; end
      dly = (m_code == 0) ? 0 : (1 << m_code);
      if (lvl == 1) begin
        e_outn = 0;
        e_out = e_out || (run_len >= dly + 1);
      end else begin
        e_out = 0;
        e_outn = e_outn || (run_len >= dly + 1);
      end
      cen = (m_mode != 3);
      ren = (m_mode != 2);
      hc = ev_cap && cen;
      hr = (ev_rl || ev_cmp) && ren;
      e_irq = hc || hr;
      if (hc || hr) e_flag = hc;
      if (cfg_we) begin // R12
        m_code = int'(cfg_wdata[2:0]);
        m_mode = int'(cfg_wdata[4:3]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(out && out_n), "R1 overlap", int'(out) + int'(out_n), 1);
      chk(out == e_out, "R2 R3 R4 R5 out_o", out, e_out);
      chk(out_n == e_outn, "R2 R3 R4 R5 out_n_o", out_n, e_outn);
      chk(irq == e_irq, "R6 R7 R8 R9 irq_o", irq, e_irq);
      chk(cap_src == e_flag, "R10 cap_src_o", cap_src, e_flag);
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input int code, input int mode);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {2'(mode), 3'(code)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [2:0] ev);
    @(negedge clk);
    {ev_cap, ev_cmp, ev_rl} = ev;
    @(negedge clk);
    {ev_cap, ev_cmp, ev_rl} = 3'b000;
    idle(2);
  endtask

  initial begin
    idle(3);
    // R11 reset state
    chk(out == 0 && out_n == 0, "R11 outputs in reset", {out, out_n}, 0);
    chk(irq == 0 && cap_src == 0, "R11 irq in reset", {irq, cap_src}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R11: default zero delay, all events raise interrupts
    fire(3'b001);
    // R2 R3 R4: sweep every delay code
    for (int c = 0; c < 8; c++) begin
      wr_cfg(c, 0);
      pwm = 1'b1; idle(140);
      pwm = 1'b0; idle(140);
    end
    // R5: reversals shorter than the delay
    wr_cfg(3, 0);
    for (int k = 1; k < 12; k++) begin
      pwm = ~pwm; idle(k);
    end
    pwm = 1'b1; idle(20);
    wr_cfg(4, 0);
    for (int k = 0; k < 6; k++) begin
      pwm = ~pwm; idle(15);
    end
    pwm = 1'b0; idle(40);
    // R12: delay code changed mid-count
    wr_cfg(6, 0);
    pwm = 1'b1; idle(10);
    wr_cfg(1, 0);
    idle(10);
    pwm = 1'b0; idle(3);
    wr_cfg(7, 0);
    idle(20);
    wr_cfg(0, 0);
    idle(5);
    // R6 R7 R8 R9 R10: every strobe combination under every mode
    for (int m = 0; m < 4; m++) begin
      wr_cfg(0, m);
      for (int e = 0; e < 8; e++) fire(3'(e));
      fire(3'b100);
      fire(3'b010);
    end
    // R9: back-to-back and held strobes
    wr_cfg(0, 0);
    @(negedge clk); ev_cap = 1'b1;
    idle(3);
    ev_cap = 1'b0; ev_rl = 1'b1;
    idle(2);
    ev_rl = 1'b0;
    idle(4);
    finish_run();
  end
endmodule